// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds a parameterised number of unsigned operands in a single combinational path. The operands are taken in groups of three. Each full group goes through a three-into-two carry-save compressor, which turns three words into two words with the same total. Groups of one or two operands that cannot be compressed are passed on unchanged. This layering repeats until two words remain.

One plain ripple adder then adds those two words. It is the only place where a carry travels along the word. Every compression layer has a fixed logic depth, whatever the operand width is.

The result is wide enough that no carry is lost, even when every operand is at its largest value. An instance with one operand wires that operand straight to the output. An instance with two operands has no compression layers and goes straight to the final adder.

Top module: `csa_multi_adder`

## Requirements
- R1: `sum_o` equals the exact unsigned sum of all M operands, carried in W + clog2(M) bits, including the case where every operand is all ones.
- R2: Inside a compressor, bit i of the first output word is the XOR of bit i of the three inputs for every i below the input width, and the bit at the input width is 0.
- R3: Inside a compressor, bit 0 of the second output word is 0, and bit i (i ≥ 1) is the majority of bit i−1 of the three inputs.
- R4: The output words of every compression layer sum to exactly the sum of its input words.
- R5: A layer forms groups from input index 0 upward in threes. Group g writes its XOR word to output slot 2g and its majority word to slot 2g+1. The one or two leftover inputs follow in index order, unchanged and zero-extended.
- R6: Layers repeat until exactly two words remain. Only the final two-operand adder propagates carries, and those two words together equal the full total with no carry beyond the result width.
- R7: With M = 1 the output equals the single operand.
- R8: With M = 2 no compression takes place, and the final adder receives the two operands unchanged.
- R9: The block holds no state: the output follows the present inputs, and all-zero inputs give a zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | M*W | Packed array of M unsigned operands; operand j in bits [j*W +: W] |
| sum_o | output | W+clog2(M) | Full-width sum of all operands |

## Verification
Two things can happen in the same evaluation. A layer can pass leftover operands around its compressors while the final adder's carry reaches the top bit of the result. An instance with seven operands provokes this, because its layers leave first one and then two words ungrouped. Sweeping every operand pattern there, including all-ones inputs that drive the sum to its top bits, forces both at once. The bench judges each pattern against an arithmetic sum. Stand-alone layer instances with one and two leftovers are checked slot by slot, so a misplaced pass-through cannot hide behind a correct total.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

  // Word count after one layer: full triples become pairs, leftovers stay.
  function automatic int ops_after(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Word count at stage k when starting from m operands.
  function automatic int ops_at(input int m, input int k);
    int n;
    n = m;
    for (int i = 0; i < k; i++) begin
      if (n > 2) n = ops_after(n);
    end
    return n;
  endfunction

  // Number of compression layers needed to reach two words.
  function automatic int layer_count(input int m);
    int n;
    int c;
    n = m;
    c = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = ops_after(n);
        c++;
      end
    end
    return c;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/csa_compress3.sv
`timescale 1ns/1ps
// Three-into-two carry-save cell. WO is WI+1, or WI once the width cap is reached.
module csa_compress3 #(
  parameter int WI = 8,
  parameter int WO = WI + 1
) (
  input  logic [WI-1:0] a_i,
  input  logic [WI-1:0] b_i,
  input  logic [WI-1:0] c_i,
  output logic [WO-1:0] d_o,
  output logic [WO-1:0] e_o
);

  for (genvar i = 0; i < WO; i++) begin : g_bit
    if (i < WI) begin : g_xor
      assign d_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    end else begin : g_xtop
      assign d_o[i] = 1'b0;
    end
    if (i == 0) begin : g_e0
      assign e_o[i] = 1'b0;
    end else begin : g_maj
      assign e_o[i] = (a_i[i-1] & b_i[i-1]) | (a_i[i-1] & c_i[i-1]) |
                      (b_i[i-1] & c_i[i-1]);
    end
  end

endmodule

// File: rtl/csa_layer.sv
`timescale 1ns/1ps
// One compression layer: triples compressed, leftovers forwarded.
module csa_layer #(
  parameter int NIN = 5,
  parameter int WI  = 8,
  parameter int WO  = WI + 1,
  localparam int NOUT = csa_pkg::ops_after(NIN)
) (
  input  logic [NIN-1:0][WI-1:0]  ops_i,
  output logic [NOUT-1:0][WO-1:0] ops_o
);

  localparam int NGRP = NIN / 3;
  localparam int NREM = NIN % 3;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    csa_compress3 #(.WI(WI), .WO(WO)) u_cmp (
      .a_i(ops_i[3*g]),
      .b_i(ops_i[3*g+1]),
      .c_i(ops_i[3*g+2]),
      .d_o(ops_o[2*g]),
      .e_o(ops_o[2*g+1])
    );
  end

  for (genvar r = 0; r < NREM; r++) begin : g_rem
    assign ops_o[2*NGRP+r] = WO'(ops_i[3*NGRP+r]);
  end

endmodule

// File: rtl/csa_cpa.sv
`timescale 1ns/1ps
// Plain ripple carry-propagate adder; carry out of the top bit is provably zero.
module csa_cpa #(
  parameter int WD = 8
) (
  input  logic [WD-1:0] a_i,
  input  logic [WD-1:0] b_i,
  output logic [WD-1:0] s_o
);

  logic [WD-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < WD; i++) begin : g_rip
    assign s_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < WD - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & cy[i]) | (b_i[i] & cy[i]);
    end
  end

endmodule

// File: rtl/csa_multi_adder.sv
`timescale 1ns/1ps
module csa_multi_adder #(
  parameter int M = 9,
  parameter int W = 8,
  localparam int OW = W + $clog2(M)
) (
  input  logic [M-1:0][W-1:0] ops_i,
  output logic [OW-1:0]       sum_o
);

  localparam int NLAY  = csa_pkg::layer_count(M);
  localparam int NLAST = csa_pkg::ops_at(M, NLAY);

  logic [OW-1:0] pair_a;
  logic [OW-1:0] pair_b;

  for (genvar k = 0; k <= NLAY; k++) begin : g_stg
    localparam int NK = csa_pkg::ops_at(M, k);
    localparam int WK = csa_pkg::min_int(W + k, OW);
    logic [NK-1:0][WK-1:0] v;
    if (k == 0) begin : g_in
      assign v = ops_i;
    end else begin : g_lay
      localparam int NP = csa_pkg::ops_at(M, k - 1);
      localparam int WP = csa_pkg::min_int(W + k - 1, OW);
      csa_layer #(.NIN(NP), .WI(WP), .WO(WK)) u_layer (
        .ops_i(g_stg[k-1].v),
        .ops_o(v)
      );
    end
  end

  if (NLAST == 1) begin : g_one
    assign pair_a = OW'(g_stg[NLAY].v[0]);
    assign pair_b = '0;
    assign sum_o  = pair_a;
  end else begin : g_two
    assign pair_a = OW'(g_stg[NLAY].v[0]);
    assign pair_b = OW'(g_stg[NLAY].v[1]);
    csa_cpa #(.WD(OW)) u_cpa (
      .a_i(pair_a),
      .b_i(pair_b),
      .s_o(sum_o)
    );
  end

endmodule

// File: rtl/csa_checker.sv
`timescale 1ns/1ps
module csa_checker #(
  parameter int M  = 9,
  parameter int W  = 8,
  parameter int OW = W + $clog2(M)
) (
  input logic [M-1:0][W-1:0] ops_i,
  input logic [OW-1:0]       sum_o,
  input logic [OW-1:0]       pair_a,
  input logic [OW-1:0]       pair_b
);

  function automatic logic [OW:0] total(input logic [M-1:0][W-1:0] x);
    logic [OW:0] s;
    s = '0;
    for (int j = 0; j < M; j++) s += (OW+1)'(x[j]);
    return s;
  endfunction

  always_comb begin
    AST_SUM_EXACT: assert (sum_o == total(ops_i)[OW-1:0] && !total(ops_i)[OW]); // R1
    AST_PAIR_HOLDS_TOTAL: assert (({1'b0, pair_a} + {1'b0, pair_b}) == total(ops_i)); // R6
    AST_FINAL_ADD: assert (sum_o == OW'(pair_a + pair_b)); // R6
    AST_SINGLE_PASS: assert (M != 1 || sum_o == OW'(ops_i[0])); // R7
    AST_DIRECT_PAIR: assert (M != 2 || (pair_a == OW'(ops_i[0]) && pair_b == OW'(ops_i[M-1]))); // R8
  end

endmodule

bind csa_multi_adder csa_checker #(.M(M), .W(W), .OW(OW)) u_chk (
  .ops_i (ops_i),
  .sum_o (sum_o),
  .pair_a(pair_a),
  .pair_b(pair_b)
);

// File: tb/tb_csa_multi_adder.sv
`timescale 1ns/1ps
module tb_csa_multi_adder;

  logic clk;
  logic rst_n;
  int   checks;
  int   fails;
  bit   done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Full adders under test
  logic [4:0][2:0] ops5;  logic [5:0] sum5;
  logic [6:0][1:0] ops7;  logic [4:0] sum7;
  logic [1:0][3:0] ops2;  logic [4:0] sum2;
  logic [0:0][3:0] ops1;  logic [3:0] sum1;
  // Building blocks under test
  logic [2:0] ca, cb, cc;  logic [3:0] cd, ce;
  logic [4:0][1:0] l5i;    logic [3:0][2:0] l5o;
  logic [3:0][1:0] l4i;    logic [2:0][2:0] l4o;

  csa_multi_adder #(.M(5), .W(3)) dut  (.ops_i(ops5), .sum_o(sum5));
  csa_multi_adder #(.M(7), .W(2)) u_m7 (.ops_i(ops7), .sum_o(sum7));
  csa_multi_adder #(.M(2), .W(4)) u_m2 (.ops_i(ops2), .sum_o(sum2));
  csa_multi_adder #(.M(1), .W(4)) u_m1 (.ops_i(ops1), .sum_o(sum1));
  csa_compress3 #(.WI(3), .WO(4)) u_c3 (.a_i(ca), .b_i(cb), .c_i(cc), .d_o(cd), .e_o(ce));
  csa_layer #(.NIN(5), .WI(2), .WO(3)) u_l5 (.ops_i(l5i), .ops_o(l5o));
  csa_layer #(.NIN(4), .WI(2), .WO(3)) u_l4 (.ops_i(l4i), .ops_o(l4o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fsum(input int v, input int n, input int w);
    int s;
    s = 0;
    for (int j = 0; j < n; j++) s += (v >> (j * w)) & ((1 << w) - 1);
    return s;
  endfunction

  function automatic int maj2(input int a, input int b, input int c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    ops5 = '0; ops7 = '0; ops2 = '0; ops1 = '0;
    ca = '0; cb = '0; cc = '0; l5i = '0; l4i = '0;
    repeat (2) @(negedge clk);
    #1;
    // R9: no state, zero inputs give zero
    chk("R9 zero m5", int'(sum5), 0);
    chk("R9 zero m7", int'(sum7), 0);
    chk("R9 zero m2", int'(sum2), 0);
    chk("R9 zero m1", int'(sum1), 0);
    rst_n = 1'b1;

    // R1: all operands at maximum
    @(negedge clk); ops5 = '1; ops7 = '1; #1;
    chk("R1 all-max m5", int'(sum5), 35);
    chk("R6 all-max m7", int'(sum7), 21);

    // R1/R9: every pattern of five 3-bit operands
    for (int v = 0; v < 32768; v++) begin
      @(negedge clk); ops5 = 15'(v); #1;
      chk("R1 sweep m5", int'(sum5), fsum(v, 5, 3));
    end
    // R6: seven operands, leftovers of one then two across four layers
    for (int v = 0; v < 16384; v++) begin
      @(negedge clk); ops7 = 14'(v); #1;
      chk("R6 sweep m7", int'(sum7), fsum(v, 7, 2));
    end
    // R8: two operands
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); ops2 = 8'(v); #1;
      chk("R8 sweep m2", int'(sum2), fsum(v, 2, 4));
    end
    // R7: one operand
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); ops1 = 4'(v); #1;
      chk("R7 pass m1", int'(sum1), v);
    end
    // R2/R3: compressor bit rules
    for (int v = 0; v < 512; v++) begin
      int a, b, c;
      a = v & 7; b = (v >> 3) & 7; c = (v >> 6) & 7;
      @(negedge clk); ca = 3'(a); cb = 3'(b); cc = 3'(c); #1;
      chk("R2 xor word", int'(cd), a ^ b ^ c);
      chk("R3 majority word", int'(ce), maj2(a, b, c));
    end
    // R4/R5: layer with two leftovers
    for (int v = 0; v < 1024; v++) begin
      int x0, x1, x2;
      x0 = v & 3; x1 = (v >> 2) & 3; x2 = (v >> 4) & 3;
      @(negedge clk); l5i = 10'(v); #1;
      chk("R5 l5 slot0", int'(l5o[0]), x0 ^ x1 ^ x2);
      chk("R5 l5 slot1", int'(l5o[1]), maj2(x0, x1, x2));
      chk("R5 l5 slot2", int'(l5o[2]), (v >> 6) & 3);
      chk("R5 l5 slot3", int'(l5o[3]), (v >> 8) & 3);
      chk("R4 l5 total", int'(l5o[0]) + int'(l5o[1]) + int'(l5o[2]) + int'(l5o[3]),
          fsum(v, 5, 2));
    end
    // R4/R5: layer with one leftover
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); l4i = 8'(v); #1;
      chk("R5 l4 slot2", int'(l4o[2]), (v >> 6) & 3);
      chk("R4 l4 total", int'(l4o[0]) + int'(l4o[1]) + int'(l4o[2]), fsum(v, 4, 2));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule